// File: doc/BRIEF.md
# Parallel Expander Allocation Chain

This block decides how spare product terms are lent between neighbouring logic cells. A group of sixteen cells is split into two independent chains of eight. Cells 0 to 7 form one chain and cells 8 to 15 form the other. Every cell owns five local product terms. A cell that needs more can borrow whole sets of terms from the cells just below it in its own chain. It may take up to three sets, and each set holds up to five terms, so a cell can have at most twenty terms. Each borrowed set adds one unit to the cell's reported expander delay.

Software or a compiler stage loads a 5-bit term request for every cell and pulses `start_i`. The block captures the requests at once. It then works through each chain from the highest cell down to the lowest, one cell per clock, with both chains stepping together. When the lowest cell has been handled it raises `done_o` for one cycle. For every cell the results give the number of sets, the lending cell and term count of each set, the delay count, and an error flag. Allocation is greedy from the top of the chain. A cell that lends its terms keeps none for itself.

Top module: `pexp_group`

## Requirements
- R1: After reset `done_o` is low and every result output (`err_o`, `set_cnt_o`, `delay_o`, `lender_o`, `terms_o`) is zero.
- R2: A `start_i` sampled high while idle captures all sixteen requests. `done_o` is high for exactly one cycle, 8 cycles after the capturing edge (9 rising edges counting it). The results then stay unchanged, whatever `req_i` does, until the next accepted start.
- R3: A cell that is not lending and requests 0 to 5 terms gets zero sets, delay 0, no error, and all set slots zero.
- R4: A cell that is not lending and requests r terms, with 6 ≤ r ≤ 20, gets n = ceil((r−5)/5) sets. Set k (k = 0,1,2, in field k of `lender_o` and `terms_o`) comes from global cell index minus 1 minus k and carries min(5, r−5−5k) terms. For example, a request of 14 on cell 7 gives sets from cells 6 and 5 with 5 and 4 terms. Slots k ≥ n read zero.
- R5: `delay_o` of every cell equals its number of borrowed sets.
- R6: A request above 20 sets the cell's error flag and leaves its allocation empty. No neighbour is consumed, so lower cells can still borrow from those neighbours.
- R7: A cell whose request needs more sets than there are lower cells in its own chain reports an error with an empty allocation. Cells 0 and 8 can never borrow, and borrowing never crosses from one chain into the other.
- R8: A cell already taken as a lender by a higher cell reports an error with an empty allocation if its own request is non-zero. It reports no error if its request is zero. It is never lent twice.
- R9: A `start_i` pulse while a run is in progress is ignored. The run ends on time with results computed from the requests captured at its own start.
- R10: The two chains work independently. The same requests in both chains give the same results, with lender indices in the upper chain offset by 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, taken when idle |
| req_i | input | 80 | Term request of cell g in bits [5g+4:5g] |
| done_o | output | 1 | One-cycle pulse when a run finishes |
| err_o | output | 16 | Per-cell request error |
| set_cnt_o | output | 32 | Borrowed set count of cell g in bits [2g+1:2g] |
| delay_o | output | 32 | Expander delay count of cell g in bits [2g+1:2g] |
| lender_o | output | 192 | Lending cell (global index) of set k of cell g in bits [4(3g+k)+3:4(3g+k)] |
| terms_o | output | 144 | Terms taken in set k of cell g in bits [3(3g+k)+2:3(3g+k)] |

## Verification
The assertions rely on requests and the start strobe being held steady through each clock edge. They also rely on reset being released only after the first edge, so the cursor, busy flag and taken mask start from known values. The directed tasks change `req_i` and `start_i` only on falling edges, and they pulse start while busy just once, in the middle of a run. Under those conditions the lending checks in each chain stay meaningful: no cell is lent twice, the lender count matches the reported set count, and the taken mask only grows during a run.

// File: rtl/pexp_pkg.sv
package pexp_pkg;
    localparam int CELLS       = 8;
    localparam int CHAINS      = 2;
    localparam int LOCAL_TERMS = 5;
    localparam int SET_TERMS   = 5;
    localparam int MAX_SETS    = 3;
    localparam int REQ_W       = 5;
    localparam int IDX_W       = $clog2(CELLS);
    localparam int SET_W       = $clog2(MAX_SETS + 1);
    localparam int TERM_W      = $clog2(SET_TERMS + 1);
    localparam int MAX_REQ     = LOCAL_TERMS + MAX_SETS * SET_TERMS;

    typedef struct packed {
        logic                              err;
        logic [SET_W-1:0]                  sets;
        logic [MAX_SETS-1:0][IDX_W-1:0]    lender;
        logic [MAX_SETS-1:0][TERM_W-1:0]   terms;
    } cell_res_t;
endpackage

// File: rtl/pexp_seq.sv
module pexp_seq
    import pexp_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    output logic             load_o,
    output logic             step_o,
    output logic [IDX_W-1:0] cursor_o,
    output logic             done_o
);
    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] cursor;
        logic             done;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy   = 1'b1;
                st_d.cursor = IDX_W'(CELLS - 1);
            end
        end else if (st_q.cursor == '0) begin
            st_d.busy = 1'b0;
            st_d.done = 1'b1;
        end else begin
            st_d.cursor = st_q.cursor - IDX_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign load_o   = start_i && !st_q.busy;
    assign step_o   = st_q.busy;
    assign cursor_o = st_q.cursor;
    assign done_o   = st_q.done;

    // R2
    done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.done |=> !st_q.done);

    // R2
    done_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.busy && st_q.cursor == '0) |=> (st_q.done && !st_q.busy));

    // R9
    busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.busy && st_q.cursor != '0) |=>
            (st_q.busy && st_q.cursor == $past(st_q.cursor) - IDX_W'(1)));
endmodule

// File: rtl/pexp_cell_alloc.sv
module pexp_cell_alloc
    import pexp_pkg::*;
(
    input  logic [IDX_W-1:0] idx_i,
    input  logic [REQ_W-1:0] req_i,
    input  logic [CELLS-1:0] taken_i,
    output cell_res_t        res_o,
    output logic [CELLS-1:0] grab_o
);
    logic [REQ_W-1:0] extra;
    logic [REQ_W-1:0] left;
    logic [SET_W-1:0] nsets;
    logic [IDX_W-1:0] lend;
    logic             blocked;

    always_comb begin
        res_o   = '0;
        grab_o  = '0;
        extra   = req_i - REQ_W'(LOCAL_TERMS);
        left    = '0;
        lend    = '0;
        nsets   = '0;
        blocked = 1'b0;
        for (int k = 0; k < MAX_SETS; k++) begin
            if (req_i > REQ_W'(LOCAL_TERMS + k * SET_TERMS)) nsets = SET_W'(k + 1);
        end
        for (int k = 0; k < MAX_SETS; k++) begin
            if (SET_W'(k) < nsets) begin
                if (IDX_W'(k) >= idx_i)                   blocked = 1'b1;
                else if (taken_i[idx_i - IDX_W'(k + 1)]) blocked = 1'b1;
            end
        end
        if (taken_i[idx_i]) begin
            res_o.err = (req_i != '0);
        end else if (req_i > REQ_W'(MAX_REQ) || blocked) begin
            res_o.err = 1'b1;
        end else begin
            res_o.sets = nsets;
            for (int k = 0; k < MAX_SETS; k++) begin
                if (SET_W'(k) < nsets) begin
                    lend            = idx_i - IDX_W'(k + 1);
                    left            = extra - REQ_W'(k * SET_TERMS);
                    res_o.lender[k] = lend;
                    grab_o[lend]    = 1'b1;
                    res_o.terms[k]  = (left >= REQ_W'(SET_TERMS)) ? TERM_W'(SET_TERMS)
                                                                  : TERM_W'(left);
                end
            end
        end
    end
endmodule

// File: rtl/pexp_chain.sv
module pexp_chain
    import pexp_pkg::*;
(
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        load_i,
    input  logic                        step_i,
    input  logic [IDX_W-1:0]            cursor_i,
    input  logic [CELLS-1:0][REQ_W-1:0] req_i,
    output cell_res_t [CELLS-1:0]       res_o
);
    typedef struct packed {
        logic [CELLS-1:0][REQ_W-1:0] req;
        cell_res_t [CELLS-1:0]       res;
        logic [CELLS-1:0]            taken;
    } chain_st_t;

    chain_st_t        st_d, st_q;
    cell_res_t        cur_res;
    logic [CELLS-1:0] grab;

    pexp_cell_alloc i_alloc (
        .idx_i   (cursor_i),
        .req_i   (st_q.req[cursor_i]),
        .taken_i (st_q.taken),
        .res_o   (cur_res),
        .grab_o  (grab)
    );

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.req   = req_i;
            st_d.res   = '0;
            st_d.taken = '0;
        end else if (step_i) begin
            st_d.res[cursor_i] = cur_res;
            st_d.taken         = st_q.taken | grab;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign res_o = st_q.res;

    // R8
    lend_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        step_i |-> ((grab & st_q.taken) == '0));

    // R4
    grab_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        step_i |-> ($countones(grab) == int'(cur_res.sets)));

    // R8
    taken_grow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && !load_i) |=> ((st_q.taken & $past(st_q.taken)) == $past(st_q.taken)));
endmodule

// File: rtl/pexp_group.sv
module pexp_group
    import pexp_pkg::*;
#(
    localparam int NC     = CELLS * CHAINS,
    localparam int GIDX_W = $clog2(NC)
) (
    input  logic                            clk_i,
    input  logic                            rst_ni,
    input  logic                            start_i,
    input  logic [NC*REQ_W-1:0]             req_i,
    output logic                            done_o,
    output logic [NC-1:0]                   err_o,
    output logic [NC*SET_W-1:0]             set_cnt_o,
    output logic [NC*SET_W-1:0]             delay_o,
    output logic [NC*MAX_SETS*GIDX_W-1:0]   lender_o,
    output logic [NC*MAX_SETS*TERM_W-1:0]   terms_o
);
    logic             load;
    logic             step;
    logic [IDX_W-1:0] cursor;

    pexp_seq i_seq (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .start_i  (start_i),
        .load_o   (load),
        .step_o   (step),
        .cursor_o (cursor),
        .done_o   (done_o)
    );

    for (genvar ch = 0; ch < CHAINS; ch++) begin : g_chain
        cell_res_t [CELLS-1:0] res;

        pexp_chain i_chain (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .load_i   (load),
            .step_i   (step),
            .cursor_i (cursor),
            .req_i    (req_i[ch*CELLS*REQ_W +: CELLS*REQ_W]),
            .res_o    (res)
        );

        for (genvar c = 0; c < CELLS; c++) begin : g_cell
            localparam int G = ch * CELLS + c;
            assign err_o[G]                   = res[c].err;
            assign set_cnt_o[G*SET_W +: SET_W] = res[c].sets;
            assign delay_o[G*SET_W +: SET_W]   = res[c].sets;
            for (genvar k = 0; k < MAX_SETS; k++) begin : g_set
                assign lender_o[(G*MAX_SETS+k)*GIDX_W +: GIDX_W] =
                    (SET_W'(k) < res[c].sets) ? (GIDX_W'(ch * CELLS) + GIDX_W'(res[c].lender[k]))
                                              : '0;
                assign terms_o[(G*MAX_SETS+k)*TERM_W +: TERM_W] = res[c].terms[k];
            end
        end
    end
endmodule

// File: tb/test_pexp_group.sv
module test_pexp_group;
    localparam int CLK_PERIOD = 10;

    logic         clk_i = 1'b0;
    logic         rst_ni = 1'b0;
    logic         start_i = 1'b0;
    logic [79:0]  req_i = '0;
    logic         done_o;
    logic [15:0]  err_o;
    logic [31:0]  set_cnt_o;
    logic [31:0]  delay_o;
    logic [191:0] lender_o;
    logic [143:0] terms_o;

    int n_vec = 0;
    int n_bad = 0;
    int mreq[16];
    int e_err[16];
    int e_sets[16];
    int e_lend[16][3];
    int e_term[16][3];

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    pexp_group i_pexp_group (
        .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .req_i(req_i),
        .done_o(done_o), .err_o(err_o), .set_cnt_o(set_cnt_o), .delay_o(delay_o),
        .lender_o(lender_o), .terms_o(terms_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model();
        for (int ch = 0; ch < 2; ch++) begin
            bit taken[8];
            for (int c = 0; c < 8; c++) taken[c] = 0;
            for (int c = 7; c >= 0; c--) begin
                int g = ch * 8 + c;
                int r = mreq[g];
                e_err[g] = 0; e_sets[g] = 0;
                for (int k = 0; k < 3; k++) begin e_lend[g][k] = 0; e_term[g][k] = 0; end
                if (taken[c]) e_err[g] = (r != 0);
                else if (r > 20) e_err[g] = 1;
                else if (r > 5) begin
                    int n = (r - 5 + 4) / 5;
                    bit bad = (n > c);
                    for (int k = 0; k < n; k++) if (!bad && taken[c-1-k]) bad = 1;
                    if (bad) e_err[g] = 1;
                    else begin
                        e_sets[g] = n;
                        for (int k = 0; k < n; k++) begin
                            taken[c-1-k] = 1;
                            e_lend[g][k] = g - 1 - k;
                            e_term[g][k] = (r - 5 - 5*k) > 5 ? 5 : (r - 5 - 5*k);
                        end
                    end
                end
            end
        end
    endtask

    function automatic logic [25:0] act_vec(input int g);
        return {err_o[g], set_cnt_o[g*2 +: 2], delay_o[g*2 +: 2],
                lender_o[g*12 +: 12], terms_o[g*9 +: 9]};
    endfunction

    function automatic logic [25:0] exp_vec(input int g);
        return {e_err[g][0], e_sets[g][1:0], e_sets[g][1:0],
                e_lend[g][2][3:0], e_lend[g][1][3:0], e_lend[g][0][3:0],
                e_term[g][2][2:0], e_term[g][1][2:0], e_term[g][0][2:0]};
    endfunction

    task automatic check_all(input string tag);
        for (int g = 0; g < 16; g++) begin
            logic [25:0] a = act_vec(g);
            logic [25:0] e = exp_vec(g);
            n_vec++;
            if (a !== e) begin
                n_bad++;
                $display("FAIL %s cell %0d actual=%h expected=%h", tag, g, a, e);
            end
        end
    endtask

    task automatic drive_req();
        for (int g = 0; g < 16; g++) req_i[g*5 +: 5] = 5'(mreq[g]);
    endtask

    task automatic wait_done(output int cyc);
        cyc = 0;
        while (!done_o && cyc < 20) begin @(negedge clk_i); cyc++; end
    endtask

    task automatic run(input string tag);
        int cyc;
        drive_req();
        start_i = 1'b1;
        @(negedge clk_i);
        start_i = 1'b0;
        wait_done(cyc);
        check(cyc == 8, "R2 done latency", cyc, 8);
        model();
        check_all(tag);
    endtask

    task automatic clear_req();
        for (int g = 0; g < 16; g++) mreq[g] = 0;
    endtask

    task automatic t_reset();
        check(done_o == 1'b0, "R1 done after reset", int'(done_o), 0);
        check({err_o, set_cnt_o, delay_o} == '0, "R1 flags after reset",
              int'(err_o), 0);
        check(lender_o == '0 && terms_o == '0, "R1 slots after reset",
              int'(lender_o[31:0]), 0);
    endtask

    task automatic t_small();
        for (int g = 0; g < 16; g++) mreq[g] = g % 6;
        run("R3 small requests");
    endtask

    task automatic t_example();
        clear_req();
        mreq[7] = 14; mreq[3] = 11; mreq[15] = 20; mreq[11] = 6;
        run("R4 borrow fields");
        check(set_cnt_o[14 +: 2] == 2, "R4 cell7 sets", int'(set_cnt_o[14 +: 2]), 2);
        check(lender_o[84 +: 8] == {4'd5, 4'd6}, "R4 cell7 lenders",
              int'(lender_o[84 +: 8]), 8'h56);
        check(terms_o[63 +: 6] == {3'd4, 3'd5}, "R4 cell7 terms",
              int'(terms_o[63 +: 6]), 6'o45);
        check(delay_o[14 +: 2] == 2, "R5 cell7 delay", int'(delay_o[14 +: 2]), 2);
        check(delay_o[30 +: 2] == 3, "R5 cell15 delay", int'(delay_o[30 +: 2]), 3);
    endtask

    task automatic t_over();
        clear_req();
        mreq[7] = 21; mreq[6] = 16; mreq[15] = 31; mreq[14] = 9;
        run("R6 over limit");
        check(err_o[7] == 1'b1, "R6 cell7 err", int'(err_o[7]), 1);
        check(set_cnt_o[12 +: 2] == 3, "R6 cell6 still borrows", int'(set_cnt_o[12 +: 2]), 3);
    endtask

    task automatic t_ends();
        clear_req();
        mreq[0] = 6; mreq[2] = 20; mreq[3] = 20; mreq[8] = 5; mreq[9] = 6;
        run("R7 chain ends");
        check(err_o[0] == 1'b1, "R7 cell0 cannot borrow", int'(err_o[0]), 1);
        check(lender_o[9*12 +: 4] == 8, "R7 cell9 lender", int'(lender_o[9*12 +: 4]), 8);
    endtask

    task automatic t_lender();
        clear_req();
        mreq[7] = 10; mreq[6] = 3; mreq[5] = 8; mreq[4] = 0;
        mreq[15] = 15; mreq[14] = 0; mreq[13] = 1; mreq[12] = 7;
        run("R8 lenders");
        check(err_o[6] == 1'b1, "R8 taken cell6 err", int'(err_o[6]), 1);
        check(err_o[14] == 1'b0, "R8 taken cell14 idle", int'(err_o[14]), 0);
    endtask

    task automatic t_busy();
        int cyc;
        clear_req();
        mreq[7] = 12; mreq[10] = 18; mreq[1] = 4;
        drive_req();
        start_i = 1'b1;
        @(negedge clk_i);
        start_i = 1'b0;
        @(negedge clk_i); @(negedge clk_i);
        req_i = {16{5'd19}};
        start_i = 1'b1;
        @(negedge clk_i);
        start_i = 1'b0;
        cyc = 3;
        while (!done_o && cyc < 20) begin @(negedge clk_i); cyc++; end
        check(cyc == 8, "R9 start ignored while busy", cyc, 8);
        model();
        check_all("R9 results from first capture");
    endtask

    task automatic t_hold();
        logic [25:0] snap;
        clear_req();
        mreq[7] = 17; mreq[12] = 9;
        run("R2 run");
        snap = act_vec(7);
        @(negedge clk_i);
        check(done_o == 1'b0, "R2 done one cycle", int'(done_o), 0);
        req_i = {16{5'd13}};
        repeat (4) @(negedge clk_i);
        check(act_vec(7) == snap, "R2 results held", int'(act_vec(7)), int'(snap));
    endtask

    task automatic t_indep();
        for (int c = 0; c < 8; c++) begin
            mreq[c] = (c * 7 + 3) % 13;
            mreq[c + 8] = mreq[c];
        end
        run("R10 mirrored chains");
        for (int c = 0; c < 8; c++) begin
            logic [25:0] lo = act_vec(c);
            logic [25:0] hi = act_vec(c + 8);
            logic [11:0] adj = lo[20:9];
            for (int k = 0; k < 3; k++)
                if (k < int'(lo[24:23])) adj[k*4 +: 4] = adj[k*4 +: 4] + 4'd8;
            check({lo[25:21], adj, lo[8:0]} == hi, "R10 chain match",
                  int'(hi), int'({lo[25:21], adj, lo[8:0]}));
        end
    endtask

    task automatic t_mix();
        int unsigned x = 32'h1234_5678;
        for (int n = 0; n < 8; n++) begin
            for (int g = 0; g < 16; g++) begin
                x = x * 1103515245 + 12345;
                mreq[g] = int'((x >> 16) % 22);
            end
            run("R4 R8 mixed pattern");
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        t_reset();
        t_small();
        t_example();
        t_over();
        t_ends();
        t_lender();
        t_busy();
        t_hold();
        t_indep();
        t_mix();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule